// File: doc/BRIEF.md
# Battery Protection Sampling Controller

This block sits behind the analog front end of a multi-cell battery monitor and decides when the pack must be cut off. It takes raw comparator flags for over-charge, over-discharge and over-current, passes each through its own detect and release delay, and raises a pack-disable output while any protection state is held. A millisecond tick is its time base. All delays and the sampling duty cycle are counted in these ticks.

To save power in normal operation, the over-charge and over-discharge comparators are switched on only for a short window in each sampling period. The block drives that enable to the analog side and ignores those two flags outside the window. Over-current is filtered all the time. When the mode bits select any monitor setting, the voltage comparators stay enabled continuously. An 8-bit status byte reports the protection states, the regulator condition and the charge-enable result.

Top module: `batt_prot_seq`

## Requirements
- R1: After reset, no protection state is held: pack_off_o is 0, status_o is 0x00 when reg_ok_i=1 and ce_flag_i=0, and vsense_en_o is 1 because a sampling window starts at reset.
- R2: With mode_i=000, vsense_en_o is 1 during the first WINDOW_MS ticks of each PERIOD_MS-tick period and 0 for the remaining ticks. With the defaults 2 and 125, it is high after 0 and 1 ticks, low after ticks 2 to 124, and high again after tick 125.
- R3: With mode_i other than 000, vsense_en_o stays 1 on every cycle.
- R4: Over-current filtering runs whatever vsense_en_o is, including outside the sampling window in mode 000.
- R5: A protection state is entered on the tick that completes its detect delay, provided the flag has stayed high on every sampled cycle since the count began. It is left on the tick that completes its release delay, provided the flag has stayed low in the same way. Each of the three types has its own detect and release delay, counted in ticks. A delay of 0 acts on the first enabled cycle.
- R6: A sampled cycle on which the flag again agrees with the current state restarts the delay count from zero.
- R7: While vsense_en_o is 0, the over-charge and over-discharge flags are ignored, and their states and delay counts hold until the next window.
- R8: pack_off_o is 1 exactly when at least one of the three protection states is held.
- R9: status_o[0] is 1 when reg_ok_i is 0 or the over-current state is held. Otherwise it is 0.
- R10: status_o[1] is 1 exactly when the over-discharge state is held.
- R11: With chg_sw_off_i=0, status_o[2] is ce_flag_i OR the over-charge state. With chg_sw_off_i=1, it is the over-charge state alone.
- R12: status_o[7:3] always reads 0.
- R13: A return of mode_i to 000 from any other value restarts the sampling period. vsense_en_o is 1 in that cycle and for the next WINDOW_MS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| mode_i | input | 3 | Analog-select mode. 000 means normal (duty-cycled) operation. Any other value is a monitor setting |
| ov_flag_i | input | 1 | Over-charge comparator output |
| uv_flag_i | input | 1 | Over-discharge comparator output |
| oc_flag_i | input | 1 | Over-current comparator output |
| ce_flag_i | input | 1 | Cell charge-enable comparator output |
| reg_ok_i | input | 1 | Regulator within tolerance |
| chg_sw_off_i | input | 1 | Configuration bit: 1 switches the charge-enable function off |
| ov_det_dly_i | input | DLY_W | Over-charge detect delay, in ticks |
| ov_rel_dly_i | input | DLY_W | Over-charge release delay, in ticks |
| uv_det_dly_i | input | DLY_W | Over-discharge detect delay, in ticks |
| uv_rel_dly_i | input | DLY_W | Over-discharge release delay, in ticks |
| oc_det_dly_i | input | DLY_W | Over-current detect delay, in ticks |
| oc_rel_dly_i | input | DLY_W | Over-current release delay, in ticks |
| vsense_en_o | output | 1 | Enable for the voltage comparators |
| pack_off_o | output | 1 | Pack disable |
| status_o | output | 8 | Status byte |

## Verification
Two events can land on the same tick: the tick that closes a sampling window, and the tick that would complete a voltage delay. The bench sets up this collision by raising the over-charge flag while the window is closed and stepping ticks up to the period wrap. The wrap tick must leave the state unchanged, because the window was still closed in the cycle it was sampled. The first tick inside the reopened window must then set the state. A second case puts a mode return to 000 on the same cycle as a closed window. This checks that the restart reopens sensing at once and does not wait for the old count.

// File: rtl/batt_prot_pkg.sv
package batt_prot_pkg;
  localparam int PROT_N = 3;
  localparam int IDX_OV = 0;
  localparam int IDX_UV = 1;
  localparam int IDX_OC = 2;

  localparam int ST_REG = 0;
  localparam int ST_UV  = 1;
  localparam int ST_CHG = 2;

  localparam logic [2:0] MODE_NORMAL = 3'b000;
endpackage

// File: rtl/sample_timer.sv
module sample_timer #(
  parameter int PERIOD_MS = 125,
  parameter int WINDOW_MS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [2:0] mode_i,
  output logic       sense_en_o
);
  import batt_prot_pkg::*;

  localparam int CNT_W = (PERIOD_MS > 1) ? $clog2(PERIOD_MS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_MS - 1);
  localparam logic [CNT_W-1:0] WIN  = CNT_W'(WINDOW_MS);

  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       mode_q;
  logic             normal, restart;

  assign normal  = (mode_i == MODE_NORMAL);
  assign restart = normal && (mode_q != MODE_NORMAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mode_q <= MODE_NORMAL;
    end else begin
      mode_q <= mode_i;
      if (restart)                cnt_q <= '0;
      else if (tick_i) begin
        if (cnt_q >= LAST)        cnt_q <= '0;
        else                      cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // restart reopens the window in the same cycle, ahead of the stale count
  assign sense_en_o = !normal || restart || (cnt_q < WIN);

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R13
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (normal && mode_q != MODE_NORMAL) |=> (cnt_q == '0));
endmodule

// File: rtl/prot_filter.sv
module prot_filter #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             flag_i,
  input  logic [DLY_W-1:0] det_dly_i,
  input  logic [DLY_W-1:0] rel_dly_i,
  output logic             act_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             act_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly;
  logic             mismatch, done;

  assign dly      = act_q ? rel_dly_i : det_dly_i;
  assign mismatch = (flag_i != act_q);
  assign done     = (dly == '0) || (tick_i && (cnt_q >= dly - ONE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (en_i) begin
      if (!mismatch) begin
        cnt_q <= '0;
      end else if (done) begin
        act_q <= flag_i;
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act_o = act_q;

  // R7
  gated_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(act_q) && $stable(cnt_q)));
  // R6
  glitch_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (flag_i == act_q)) |=> (cnt_q == '0));
  // R5
  enter_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> ($past(flag_i) && $past(en_i)));
  // R5
  leave_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> (!$past(flag_i) && $past(en_i)));
endmodule

// File: rtl/batt_prot_seq.sv
module batt_prot_seq
  import batt_prot_pkg::*;
#(
  parameter int PERIOD_MS = 125,
  parameter int WINDOW_MS = 2,
  parameter int DLY_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ms_tick_i,
  input  logic [2:0]       mode_i,
  input  logic             ov_flag_i,
  input  logic             uv_flag_i,
  input  logic             oc_flag_i,
  input  logic             ce_flag_i,
  input  logic             reg_ok_i,
  input  logic             chg_sw_off_i,
  input  logic [DLY_W-1:0] ov_det_dly_i,
  input  logic [DLY_W-1:0] ov_rel_dly_i,
  input  logic [DLY_W-1:0] uv_det_dly_i,
  input  logic [DLY_W-1:0] uv_rel_dly_i,
  input  logic [DLY_W-1:0] oc_det_dly_i,
  input  logic [DLY_W-1:0] oc_rel_dly_i,
  output logic             vsense_en_o,
  output logic             pack_off_o,
  output logic [7:0]       status_o
);
  logic                vsense_en;
  logic [PROT_N-1:0]   flag_v, en_v, act_v;
  logic [DLY_W-1:0]    det_v [PROT_N];
  logic [DLY_W-1:0]    rel_v [PROT_N];
  logic                st_chg;

  sample_timer #(
    .PERIOD_MS (PERIOD_MS),
    .WINDOW_MS (WINDOW_MS)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ms_tick_i),
    .mode_i     (mode_i),
    .sense_en_o (vsense_en)
  );

  assign flag_v[IDX_OV] = ov_flag_i;
  assign flag_v[IDX_UV] = uv_flag_i;
  assign flag_v[IDX_OC] = oc_flag_i;
  assign en_v[IDX_OV]   = vsense_en;
  assign en_v[IDX_UV]   = vsense_en;
  assign en_v[IDX_OC]   = 1'b1;
  assign det_v[IDX_OV]  = ov_det_dly_i;
  assign rel_v[IDX_OV]  = ov_rel_dly_i;
  assign det_v[IDX_UV]  = uv_det_dly_i;
  assign rel_v[IDX_UV]  = uv_rel_dly_i;
  assign det_v[IDX_OC]  = oc_det_dly_i;
  assign rel_v[IDX_OC]  = oc_rel_dly_i;

  for (genvar g = 0; g < PROT_N; g++) begin : g_flt
    prot_filter #(.DLY_W(DLY_W)) u_flt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (ms_tick_i),
      .en_i      (en_v[g]),
      .flag_i    (flag_v[g]),
      .det_dly_i (det_v[g]),
      .rel_dly_i (rel_v[g]),
      .act_o     (act_v[g])
    );
  end

  assign st_chg = act_v[IDX_OV] | (ce_flag_i & ~chg_sw_off_i);

  always_comb begin
    status_o         = '0;
    status_o[ST_REG] = ~reg_ok_i | act_v[IDX_OC];
    status_o[ST_UV]  = act_v[IDX_UV];
    status_o[ST_CHG] = st_chg;
  end

  assign vsense_en_o = vsense_en;
  assign pack_off_o  = |act_v;

  // R3
  monitor_sense_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_NORMAL) |-> vsense_en_o);
  // R4
  oc_free_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_flag_i && oc_det_dly_i == '0) |=> status_o[ST_REG]);
  // R8
  pack_off_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pack_off_o |-> (status_o[ST_UV] || act_v[IDX_OV] || act_v[IDX_OC]));
endmodule

// File: tb/batt_prot_seq_bench.sv
`timescale 1ns/1ps
module batt_prot_seq_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [2:0]    mode = 3'b000;
  logic          ov = 1'b0, uv = 1'b0, oc = 1'b0, ce = 1'b0;
  logic          reg_ok = 1'b1, sw_off = 1'b0;
  logic [DW-1:0] ov_det = 8'd1, ov_rel = 8'd1, uv_det = 8'd1;
  logic [DW-1:0] uv_rel = 8'd1, oc_det = 8'd1, oc_rel = 8'd1;
  logic          vsense, pack_off;
  logic [7:0]    status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  batt_prot_seq u_batt_prot_seq (
    .clk_i(clk), .rst_ni(rst_n), .ms_tick_i(tick), .mode_i(mode),
    .ov_flag_i(ov), .uv_flag_i(uv), .oc_flag_i(oc), .ce_flag_i(ce),
    .reg_ok_i(reg_ok), .chg_sw_off_i(sw_off),
    .ov_det_dly_i(ov_det), .ov_rel_dly_i(ov_rel),
    .uv_det_dly_i(uv_det), .uv_rel_dly_i(uv_rel),
    .oc_det_dly_i(oc_det), .oc_rel_dly_i(oc_rel),
    .vsense_en_o(vsense), .pack_off_o(pack_off), .status_o(status)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 1'b0; mode = 3'b000;
    ov = 0; uv = 0; oc = 0; ce = 0; reg_ok = 1; sw_off = 0;
    ov_det = 1; ov_rel = 1; uv_det = 1; uv_rel = 1; oc_det = 1; oc_rel = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 status", status, 8'h00);
    chk("R1 pack_off", pack_off, 0);
    chk("R1 vsense", vsense, 1);
  endtask

  task automatic t_window();
    do_reset();
    sw_off = 1'b1;
    do_tick(1);  chk("R2 after 1 tick", vsense, 1);
    do_tick(1);  chk("R2 after 2 ticks", vsense, 0);
    ov = 1'b1;
    do_tick(10);
    chk("R7 ov ignored pack_off", pack_off, 0);
    chk("R7 ov ignored status2", status[2], 0);
    do_tick(112); chk("R2 after 124 ticks", vsense, 0);
    do_tick(1);
    chk("R2 after 125 ticks", vsense, 1);
    chk("R7 wrap tick not sampled", pack_off, 0);
    do_tick(1);
    chk("R5 ov set in window", pack_off, 1);
    chk("R8 pack_off from ov", pack_off, 1);
    chk("R11 sw_off=1 ov", status[2], 1);
    chk("R12 upper zero", status[7:3], 0);
    ov = 1'b0;
    do_tick(1);
    chk("R5 ov released", pack_off, 0);
  endtask

  task automatic t_monitor();
    bit all_on = 1'b1;
    do_reset();
    mode = 3'b101;
    for (int i = 0; i < 200; i++) begin
      do_tick(1);
      if (!vsense) all_on = 1'b0;
    end
    chk("R3 vsense continuous", all_on, 1);
  endtask

  task automatic t_delay();
    do_reset();
    mode = 3'b001; uv_det = 3; uv_rel = 2;
    uv = 1'b1;
    do_tick(2); chk("R5 uv before detect", status[1], 0);
    do_tick(1);
    chk("R10 uv state", status[1], 1);
    chk("R8 pack_off from uv", pack_off, 1);
    chk("R12 upper zero uv", status[7:3], 0);
    uv = 1'b0;
    do_tick(1); chk("R5 uv before release", status[1], 1);
    do_tick(1); chk("R5 uv released", status[1], 0);
    chk("R8 pack_off clear", pack_off, 0);
  endtask

  task automatic t_glitch();
    do_reset();
    mode = 3'b010; ov_det = 4; sw_off = 1'b1;
    ov = 1'b1;
    do_tick(3);
    ov = 1'b0; @(negedge clk); ov = 1'b1;
    do_tick(3); chk("R6 restarted count", status[2], 0);
    do_tick(1); chk("R6 set after full delay", status[2], 1);
  endtask

  task automatic t_oc();
    do_reset();
    do_tick(5);
    chk("R4 window closed", vsense, 0);
    oc_det = 2; oc = 1'b1;
    do_tick(1); chk("R4 oc pending", status[0], 0);
    do_tick(1);
    chk("R4 oc set outside window", status[0], 1);
    chk("R9 oc status0", status[0], 1);
    chk("R8 pack_off from oc", pack_off, 1);
    oc = 1'b0;
    do_tick(1); chk("R4 oc released", pack_off, 0);
  endtask

  task automatic t_status();
    do_reset();
    reg_ok = 1'b0; @(negedge clk);
    chk("R9 regulator out", status, 8'h01);
    reg_ok = 1'b1; @(negedge clk);
    chk("R9 regulator ok", status[0], 0);
    ce = 1'b1; sw_off = 1'b0; @(negedge clk);
    chk("R11 ce with switch on", status, 8'h04);
    sw_off = 1'b1; @(negedge clk);
    chk("R11 ce with switch off", status[2], 0);
    chk("R12 upper zero status", status[7:3], 0);
  endtask

  task automatic t_restart();
    do_reset();
    do_tick(5); chk("R13 closed before", vsense, 0);
    mode = 3'b011;
    do_tick(3);
    mode = 3'b000;
    #1 chk("R13 reopen same cycle", vsense, 1);
    @(negedge clk); chk("R13 open after restart", vsense, 1);
    do_tick(1);     chk("R13 open after 1 tick", vsense, 1);
    do_tick(1);     chk("R13 closed after 2 ticks", vsense, 0);
  endtask

  initial begin
    t_reset();
    t_window();
    t_monitor();
    t_delay();
    t_glitch();
    t_oc();
    t_status();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule